// File: doc/BRIEF.md
# EDO DRAM Data-Output Control

This block is a clock-sampled model of the logic that governs the data outputs of an extended-data-out DRAM. Each clock it takes the row strobe, column strobe, output-enable and write-enable levels (all active low), together with the read word that an array would deliver. From these it produces a registered data word and an enable that a wrapper uses to drive a tri-state DQ bus. A controller model can be run against it to confirm that the controller's strobe sequences place read data on the bus when the controller expects it.

A read word is latched when the column strobe falls while the row strobe is low, write-enable is high and the read word is valid. In extended-data-out mode the latched word stays on the bus after the column strobe returns high. It leaves the bus only when output-enable or write-enable is used to park the outputs, or when a turn-off delay expires. In fast-page mode the bus is released as soon as the column strobe rises. A held-data flag reports whether a latched word is still available.

Top module: `edo_dout_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `dq_oe`, `held` and `dq_out` are all zero.
- R2: A column strobe fall sampled with `ras_n`=0, `we_n`=1 and `rd_valid`=1 captures `rd_data`. At the next clock edge `held`=1, and with `oe_n`=0 the outputs are `dq_oe`=1 and `dq_out` = the captured word.
- R3: In EDO mode (`EDO_MODE`=1) a captured word stays driven after `cas_n` rises, for as long as `ras_n` and `oe_n` stay low and `we_n` stays high.
- R4: In fast-page mode (`EDO_MODE`=0), in the cycle where `cas_n` is sampled rising, `dq_oe` and `held` go to zero.
- R5: If `oe_n` is high while `ras_n` and `cas_n` are both low, `dq_oe` is 0 for that cycle. When `oe_n` is low again, the same word returns with `dq_oe`=1.
- R6: In EDO mode, a change of `oe_n` sampled with `cas_n`=1 and `ras_n`=0 forces `dq_oe` to 0. It stays 0 until the next capture of R2, whatever `oe_n` does in between.
- R7: A sample with `we_n`=0, `cas_n`=1 and `ras_n`=0 forces `dq_oe` to 0. It stays 0 until the next capture.
- R8: After `TOFF_CYC` consecutive cycles sampled with `ras_n`=1 and `cas_n`=1, `held` and `dq_oe` are 0 whatever `oe_n` is. Expiry takes priority over `oe_n` falling in the same cycle.
- R9: A new capture clears the parked state of R6/R7 and drives the new word.
- R10: `dq_out` is all zeros in every cycle where `dq_oe` is 0.
- R11: A column strobe fall sampled with `rd_valid`=0 captures nothing. A low `cas_n` with no falling edge captures nothing either. In both cases `held` and the parked state are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe level, active low |
| cas_n | input | 1 | Column strobe level, active low |
| oe_n | input | 1 | Output-enable level, active low |
| we_n | input | 1 | Write-enable level, active low |
| rd_valid | input | 1 | `rd_data` holds a valid read word |
| rd_data | input | DATA_W | Read word from the array |
| dq_out | output | DATA_W | Registered output word, zero when not driven |
| dq_oe | output | 1 | Registered enable for the tri-state DQ drivers |
| held | output | 1 | A latched read word is still held |

## Verification
The turn-off timer and output-enable can act in the same cycle. Both strobes rise together while `oe_n` is high. Then `oe_n` is lowered in exactly the cycle where the `TOFF_CYC`-th both-high sample falls. The expected result is that expiry wins: `dq_oe` stays 0, `held` drops and `dq_out` reads zero. A fast-page instance is driven from the same stimulus, so the same cycles also show the column-rise release against the EDO hold.

// File: rtl/edo_pkg.sv
package edo_pkg;

  // Sampled strobe levels, all active low
  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic oe_n;
    logic we_n;
  } strobe_t;

  // Events derived from the current and previous samples
  typedef struct packed {
    logic cas_fall;
    logic cas_rise;
    logic oe_flip;
    logic both_high;
  } strobe_ev_t;

endpackage

// File: rtl/strobe_sampler.sv
module strobe_sampler
  import edo_pkg::*;
(
  input  logic       clk,
  input  strobe_t    cur,
  output strobe_ev_t ev
);

  strobe_t prev_q;

  // Captured every cycle, so the edge view matches the bus history across reset
  always_ff @(posedge clk) begin
    prev_q <= cur;
  end

  always_comb begin
    ev.cas_fall  = prev_q.cas_n & ~cur.cas_n;
    ev.cas_rise  = ~prev_q.cas_n & cur.cas_n;
    ev.oe_flip   = prev_q.oe_n ^ cur.oe_n;
    ev.both_high = cur.ras_n & cur.cas_n;
  end

endmodule

// File: rtl/toff_timer.sv
module toff_timer #(
  parameter int TOFF_CYC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expire
);

  localparam int CW = (TOFF_CYC < 2) ? 1 : $clog2(TOFF_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(TOFF_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expire = run && (cnt_q == LAST);

endmodule

// File: rtl/dout_latch.sv
module dout_latch
  import edo_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter bit EDO_MODE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           cur,
  input  strobe_ev_t        ev,
  input  logic              expire,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              held
);

  logic [DATA_W-1:0] data_q, data_d;
  logic              held_q, held_d;
  logic              park_q, park_d;
  logic              drive_d;
  logic              load, kill, park_set;

  assign load = ev.cas_fall & ~cur.ras_n & cur.we_n & rd_valid;

  generate
    if (EDO_MODE) begin : g_edo
      assign kill     = expire;
      assign park_set = ~cur.ras_n & cur.cas_n & (ev.oe_flip | ~cur.we_n);
    end else begin : g_fpm
      assign kill     = expire | ev.cas_rise;
      assign park_set = ~cur.ras_n & cur.cas_n & ~cur.we_n;
    end
  endgenerate

  always_comb begin
    held_d  = load ? 1'b1 : (kill ? 1'b0 : held_q);
    park_d  = load ? 1'b0 : (park_set ? 1'b1 : park_q);
    data_d  = load ? rd_data : data_q;
    drive_d = held_d & ~park_d & ~cur.oe_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      held_q <= 1'b0;
      park_q <= 1'b0;
      dq_oe  <= 1'b0;
      dq_out <= '0;
    end else begin
      data_q <= data_d;
      held_q <= held_d;
      park_q <= park_d;
      dq_oe  <= drive_d;
      dq_out <= drive_d ? data_d : '0;
    end
  end

  assign held = held_q;

endmodule

// File: rtl/edo_dout_ctrl.sv
module edo_dout_ctrl
  import edo_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter bit EDO_MODE = 1'b1,
  parameter int TOFF_CYC = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              held
);

  strobe_t    cur;
  strobe_ev_t ev;
  logic       expire;

  assign cur = '{ras_n: ras_n, cas_n: cas_n, oe_n: oe_n, we_n: we_n};

  strobe_sampler u_sampler (
    .clk (clk),
    .cur (cur),
    .ev  (ev)
  );

  toff_timer #(.TOFF_CYC(TOFF_CYC)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .run    (ev.both_high),
    .expire (expire)
  );

  dout_latch #(.DATA_W(DATA_W), .EDO_MODE(EDO_MODE)) u_latch (
    .clk      (clk),
    .rst      (rst),
    .cur      (cur),
    .ev       (ev),
    .expire   (expire),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .dq_out   (dq_out),
    .dq_oe    (dq_oe),
    .held     (held)
  );

endmodule

// File: rtl/edo_dout_ctrl_chk.sv
module edo_dout_ctrl_chk #(
  parameter int DATA_W   = 16,
  parameter bit EDO_MODE = 1'b1,
  parameter int TOFF_CYC = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              ras_n,
  input logic              cas_n,
  input logic              oe_n,
  input logic              we_n,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic [DATA_W-1:0] dq_out,
  input logic              dq_oe,
  input logic              held
);

  localparam int CW = (TOFF_CYC < 2) ? 1 : $clog2(TOFF_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(TOFF_CYC - 1);

  // Consecutive both-high samples before the current cycle, saturating
  logic [CW-1:0] hi_run;
  always_ff @(posedge clk) begin
    if (rst) hi_run <= '0;
    else if (ras_n && cas_n) begin
      if (hi_run != LIM) hi_run <= hi_run + 1'b1;
    end else hi_run <= '0;
  end

  assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
    ($fell(cas_n) && !ras_n && we_n && rd_valid && !oe_n)
      |=> (held && dq_oe && dq_out == $past(rd_data)));

  assert_oe_flip_park_R6: assert property (@(posedge clk) disable iff (rst)
    (!ras_n && cas_n && (oe_n != $past(oe_n))) |=> !dq_oe);

  assert_we_park_R7: assert property (@(posedge clk) disable iff (rst)
    (!ras_n && cas_n && !we_n) |=> !dq_oe);

  assert_turnoff_R8: assert property (@(posedge clk) disable iff (rst)
    (ras_n && cas_n && hi_run == LIM) |=> (!held && !dq_oe));

  assert_zero_when_off_R10: assert property (@(posedge clk) disable iff (rst)
    !dq_oe |-> (dq_out == '0));

  generate
    if (EDO_MODE) begin : g_edo_chk
      assert_edo_hold_R3: assert property (@(posedge clk) disable iff (rst)
        ($rose(cas_n) && !ras_n && !oe_n && !$past(oe_n) && we_n && dq_oe)
          |=> (dq_oe && $stable(dq_out)));
    end else begin : g_fpm_chk
      assert_fpm_release_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(cas_n) |=> (!held && !dq_oe));
    end
  endgenerate

endmodule

bind edo_dout_ctrl edo_dout_ctrl_chk #(
  .DATA_W   (DATA_W),
  .EDO_MODE (EDO_MODE),
  .TOFF_CYC (TOFF_CYC)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ras_n    (ras_n),
  .cas_n    (cas_n),
  .oe_n     (oe_n),
  .we_n     (we_n),
  .rd_valid (rd_valid),
  .rd_data  (rd_data),
  .dq_out   (dq_out),
  .dq_oe    (dq_oe),
  .held     (held)
);

// File: tb/edo_dout_ctrl_tb.sv
module edo_dout_ctrl_tb;

  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ras_n = 1'b1, cas_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, rd_valid = 1'b0;
  logic [W-1:0] rd_data = '0;
  logic [W-1:0] dq_out, f_dq_out;
  logic dq_oe, held, f_dq_oe, f_held;

  always #10 clk = ~clk;

  edo_dout_ctrl #(.DATA_W(W), .EDO_MODE(1'b1), .TOFF_CYC(3)) u_dut (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .oe_n(oe_n), .we_n(we_n),
    .rd_valid(rd_valid), .rd_data(rd_data), .dq_out(dq_out), .dq_oe(dq_oe), .held(held)
  );

  edo_dout_ctrl #(.DATA_W(W), .EDO_MODE(1'b0), .TOFF_CYC(3)) u_fpm (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .oe_n(oe_n), .we_n(we_n),
    .rd_valid(rd_valid), .rd_data(rd_data), .dq_out(f_dq_out), .dq_oe(f_dq_oe), .held(f_held)
  );

  // Scoreboard queues: {e_oe, e_held, chk_fpm, f_oe, f_held}, expected word, label
  logic [4:0]   q_bits[$];
  logic [W-1:0] q_word[$];
  string        q_tag[$];

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic step(input logic r, input logic c, input logic o, input logic w,
                      input logic v, input logic [W-1:0] d,
                      input logic eo, input logic [W-1:0] ed, input logic eh,
                      input logic cf, input logic fo, input logic fh, input string tag);
    @(negedge clk);
    ras_n = r; cas_n = c; oe_n = o; we_n = w; rd_valid = v; rd_data = d;
    q_bits.push_back({eo, eh, cf, fo, fh});
    q_word.push_back(ed);
    q_tag.push_back(tag);
    @(posedge clk);
  endtask

  // Monitor: compares one expected item per clock, after outputs settle
  always @(posedge clk) begin
    #1;
    if (q_bits.size() > 0) begin
      logic [4:0]   b;
      logic [W-1:0] wd;
      string        t;
      b  = q_bits.pop_front();
      wd = q_word.pop_front();
      t  = q_tag.pop_front();
      checks++;
      if (dq_oe !== b[4] || held !== b[3] || dq_out !== wd) begin
        fails++;
        $display("FAIL %s EDO: oe=%b held=%b dq=%h expected oe=%b held=%b dq=%h",
                 t, dq_oe, held, dq_out, b[4], b[3], wd);
      end
      if (b[2]) begin
        checks++;
        if (f_dq_oe !== b[1] || f_held !== b[0]) begin
          fails++;
          $display("FAIL %s FPM: oe=%b held=%b expected oe=%b held=%b",
                   t, f_dq_oe, f_held, b[1], b[0]);
        end
      end
    end
  end

  initial begin
    // r c o w v data      EDO: oe word held   FPM: chk oe held
    step(1,1,1,1,0,16'h0000, 0,16'h0000,0, 1,0,0, "R1 in reset");
    step(1,1,1,1,0,16'h0000, 0,16'h0000,0, 1,0,0, "R1 in reset");
    rst = 1'b0;
    step(0,1,0,1,0,16'h0000, 0,16'h0000,0, 1,0,0, "R1 after reset");
    step(0,0,0,1,1,16'hA1A1, 1,16'hA1A1,1, 1,1,1, "R2 capture");
    step(0,1,0,1,0,16'h0000, 1,16'hA1A1,1, 1,0,0, "R3/R4 cas rise");
    step(0,1,0,1,0,16'h0000, 1,16'hA1A1,1, 1,0,0, "R3 hold");
    step(0,0,0,1,1,16'hB2B2, 1,16'hB2B2,1, 1,1,1, "R2 page recapture");
    step(0,0,1,1,0,16'h0000, 0,16'h0000,1, 1,0,1, "R5 oe high cas low");
    step(0,0,0,1,0,16'h0000, 1,16'hB2B2,1, 1,1,1, "R5 same word back");
    step(0,1,0,1,0,16'h0000, 1,16'hB2B2,1, 1,0,0, "R4 fpm release");
    step(0,1,1,1,0,16'h0000, 0,16'h0000,1, 1,0,0, "R6 oe flip cas high");
    step(0,1,0,1,0,16'h0000, 0,16'h0000,1, 0,0,0, "R6 stays parked");
    step(0,0,0,1,1,16'hC3C3, 1,16'hC3C3,1, 1,1,1, "R9 recapture");
    step(0,1,0,1,0,16'h0000, 1,16'hC3C3,1, 0,0,0, "R3 hold");
    step(0,1,0,0,0,16'h0000, 0,16'h0000,1, 1,0,0, "R7 we low");
    step(0,1,0,1,0,16'h0000, 0,16'h0000,1, 0,0,0, "R7 stays parked");
    step(0,0,0,1,0,16'hD4D4, 0,16'h0000,1, 1,0,0, "R11 fall no valid");
    step(0,0,0,1,1,16'hD4D4, 0,16'h0000,1, 1,0,0, "R11 no edge");
    step(0,1,0,1,0,16'h0000, 0,16'h0000,1, 0,0,0, "R11 parked");
    step(0,0,0,1,1,16'hE5E5, 1,16'hE5E5,1, 1,1,1, "R9 recapture");
    step(1,0,0,1,0,16'h0000, 1,16'hE5E5,1, 1,1,1, "R8 ras rise only");
    step(1,1,0,1,0,16'h0000, 1,16'hE5E5,1, 1,0,0, "R8 window 1");
    step(1,1,0,1,0,16'h0000, 1,16'hE5E5,1, 0,0,0, "R8 window 2");
    step(1,1,0,1,0,16'h0000, 0,16'h0000,0, 1,0,0, "R8 expiry");
    step(0,1,0,1,0,16'h0000, 0,16'h0000,0, 0,0,0, "R10 idle");
    step(0,0,0,1,1,16'hF6F6, 1,16'hF6F6,1, 1,1,1, "R2 capture");
    step(1,1,1,1,0,16'h0000, 0,16'h0000,1, 1,0,0, "R8 both rise oe high");
    step(1,1,1,1,0,16'h0000, 0,16'h0000,1, 0,0,0, "R8 window 2");
    step(1,1,0,1,0,16'h0000, 0,16'h0000,0, 1,0,0, "R8 expiry beats oe");
    step(1,1,0,1,0,16'h0000, 0,16'h0000,0, 1,0,0, "R10 off stays zero");
    repeat (2) @(posedge clk);
    #2;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule